// File: doc/BRIEF.md
# Logarithmic PCM Compander (A-law / mu-law)

This block converts between linear audio samples and 8-bit logarithmic codes under either the A-law or the mu-law curve. It serves two users at once. Two inline lanes sit in the serial audio path. The transmit lane turns each linear word from software into a code. The receive lane turns each arriving code back into a linear word. No software action is needed beyond turning the lanes on.

A separate service port lets software run single compress or expand operations on demand. It has its own datapath, so it runs alongside inline traffic, companded or not, with no stalls and no interference.

Linear samples are two's-complement words of `DATA_W` bits. The A-law curve uses a 13-bit range (-4096..4095) and the mu-law curve a 14-bit range (-8192..8191). When the inline lanes are off, they pass the low byte through unchanged.

Top module: `pcm_compander`

## Requirements
- R1: While `rst_n` is low, every output port is zero.
- R2: A-law compress (`law_sel`=0): clip the sample to -4096..4095. Sign bit is 1 for x>=0. Magnitude m is x for x>=0, else -x-1. Segment s is 0 for m<32, else floor(log2 m)-4. Mantissa is m/2 for s=0, else (m>>s) mod 16. The code is {sign,s[2:0],mantissa} XOR 0x55.
- R3: Mu-law compress (`law_sel`=1): clip the sample to -8192..8191. Sign bit is 1 for x<0. Take m=|x|+33, limited to 8191. Segment s is floor(log2 m)-5. Mantissa is (m>>(s+1)) mod 16. The code is the bitwise inverse of {sign,s[2:0],mantissa}.
- R4: A-law expand: set t = code XOR 0x55. Magnitude is 2*t[3:0]+1 when t[6:4]=0, else (2*t[3:0]+33)<<(t[6:4]-1). The result is positive when t[7]=1 and negative otherwise, sign-extended to `DATA_W`.
- R5: Mu-law expand: set t = inverse of the code. Magnitude is ((2*t[3:0]+33)<<t[6:4])-33. The result is negative when t[7]=1.
- R6: Out-of-range inputs clip to the largest-magnitude code. A-law gives 0xAA for positive and 0x2A for negative. Mu-law gives 0x80 for positive and 0x00 for negative.
- R7: With `inline_en`=1, a word accepted on `tx_valid_i` appears as a code on `tx_code_o` one cycle later, with `tx_valid_o` high. A code accepted on `rx_valid_i` appears on `rx_word_o` one cycle later, with `rx_valid_o` high.
- R8: With `inline_en`=0, `tx_code_o` equals the low 8 bits of the accepted word. `rx_word_o` equals the accepted code zero-extended.
- R9: A service request (`svc_req_i`) returns `svc_valid_o` one cycle later. With `svc_op_i`=0, `svc_data_o` holds the compressed code zero-extended. With `svc_op_i`=1, it holds the expansion of `svc_data_i[7:0]`, and bits above 7 are ignored.
- R10: Service requests and inline transfers in the same cycle each produce their own correct result in the next cycle.
- R11: Each result register holds its value in cycles with no request on its lane. Each valid output is low the cycle after an idle input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| law_sel | input | 1 | 0 selects A-law, 1 selects mu-law |
| inline_en | input | 1 | Enables conversion in the inline lanes |
| tx_valid_i | input | 1 | Transmit word present |
| tx_word_i | input | DATA_W | Linear transmit word |
| tx_valid_o | output | 1 | Transmit code valid |
| tx_code_o | output | 8 | Transmit code (or low byte) |
| rx_valid_i | input | 1 | Receive code present |
| rx_code_i | input | 8 | Received code |
| rx_valid_o | output | 1 | Receive word valid |
| rx_word_o | output | DATA_W | Expanded (or zero-extended) word |
| svc_req_i | input | 1 | Service request |
| svc_op_i | input | 1 | 0 compress, 1 expand |
| svc_data_i | input | DATA_W | Service operand |
| svc_valid_o | output | 1 | Service result valid |
| svc_data_o | output | DATA_W | Service result |

## Verification
Every lane has the same latency. A request presented before a rising edge is converted and registered at that edge, so its result and valid flag are due one cycle after the stimulus. The bench drives all inputs on the falling edge. At each falling edge it first compares the outputs against the expectation formed one cycle earlier, then applies new stimulus and forms the next expectation. This keeps every comparison exactly one register stage behind its stimulus. Idle cycles are compared against the held value, which checks the holding behaviour at the same point.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
   typedef enum logic {LAW_A = 1'b0, LAW_MU = 1'b1} law_e;

   localparam int          CODE_W     = 8;
   localparam int          A_LIN_MAX  = 4095;
   localparam int          A_LIN_MIN  = -4096;
   localparam int          MU_LIN_MAX = 8191;
   localparam int          MU_LIN_MIN = -8192;
   localparam int          MU_BIAS    = 33;
   localparam logic [7:0]  A_FLIP     = 8'h55;

   // index of the highest set bit (0 for an all-zero input)
   function automatic int unsigned top_bit(input logic [15:0] v);
      int unsigned r;
      r = 0;
      for (int i = 0; i < 16; i++) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction
endpackage

// File: rtl/cmp_encode.sv
module cmp_encode #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] lin,
   input  cmp_pkg::law_e     law,
   output logic [7:0]        code
);
   import cmp_pkg::*;

   if (DATA_W < 14 || DATA_W > 32) begin : g_bad_width
      $error("cmp_encode: DATA_W must lie in 14..32");
   end

   int          a_x, a_m, u_x, u_m;
   int unsigned a_seg, u_seg;
   logic        a_neg, u_neg;
   logic [3:0]  a_man, u_man;
   logic [7:0]  a_code, u_code;

   // A-law: 13-bit range, one's-complement magnitude, even bits flipped
   always_comb begin
      a_x = int'($signed(lin));
      if (a_x > A_LIN_MAX)      a_x = A_LIN_MAX;
      else if (a_x < A_LIN_MIN) a_x = A_LIN_MIN;
      a_neg = (a_x < 0);
      a_m   = a_neg ? (-a_x - 1) : a_x;
      a_seg = (a_m < 32) ? 0 : top_bit(16'(a_m)) - 4;
      a_man = (a_seg == 0) ? 4'(a_m >> 1) : 4'(a_m >> a_seg);
      a_code = {~a_neg, 3'(a_seg), a_man} ^ A_FLIP;
   end

   // mu-law: 14-bit range, biased magnitude, whole code inverted
   always_comb begin
      u_x = int'($signed(lin));
      if (u_x > MU_LIN_MAX)      u_x = MU_LIN_MAX;
      else if (u_x < MU_LIN_MIN) u_x = MU_LIN_MIN;
      u_neg = (u_x < 0);
      u_m   = (u_neg ? -u_x : u_x) + MU_BIAS;
      if (u_m > MU_LIN_MAX) u_m = MU_LIN_MAX;
      u_seg = top_bit(16'(u_m)) - 5;
      u_man = 4'(u_m >> (u_seg + 1));
      u_code = ~{u_neg, 3'(u_seg), u_man};
   end

   assign code = (law == LAW_MU) ? u_code : a_code;
endmodule

// File: rtl/cmp_decode.sv
module cmp_decode #(
   parameter int DATA_W = 16
) (
   input  logic [7:0]        code,
   input  cmp_pkg::law_e     law,
   output logic [DATA_W-1:0] lin
);
   import cmp_pkg::*;

   if (DATA_W < 14 || DATA_W > 32) begin : g_bad_width
      $error("cmp_decode: DATA_W must lie in 14..32");
   end

   logic [7:0] a_t, u_t;
   int         a_mag, a_val, u_mag, u_val;

   always_comb begin
      a_t = code ^ A_FLIP;
      if (a_t[6:4] == 3'd0) a_mag = int'(a_t[3:0]) * 2 + 1;
      else                  a_mag = (int'(a_t[3:0]) * 2 + 33) << (int'(a_t[6:4]) - 1);
      a_val = a_t[7] ? a_mag : -a_mag;
   end

   always_comb begin
      u_t   = ~code;
      u_mag = ((int'(u_t[3:0]) * 2 + MU_BIAS) << u_t[6:4]) - MU_BIAS;
      u_val = u_t[7] ? -u_mag : u_mag;
   end

   assign lin = DATA_W'((law == LAW_MU) ? u_val : a_val);
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage #(
   parameter int DATA_W  = 16,
   parameter bit TO_CODE = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  cmp_pkg::law_e                       law,
   input  logic                                conv_en,
   input  logic                                in_valid,
   input  logic [(TO_CODE ? DATA_W : 8)-1:0]   in_data,
   output logic                                out_valid,
   output logic [(TO_CODE ? 8 : DATA_W)-1:0]   out_data
);
   localparam int OUT_W = TO_CODE ? 8 : DATA_W;

   logic [OUT_W-1:0] conv_d, pass_d;

   if (TO_CODE) begin : g_enc
      cmp_encode #(.DATA_W(DATA_W)) u_enc (.lin(in_data), .law(law), .code(conv_d));
      assign pass_d = in_data[7:0];
   end else begin : g_dec
      cmp_decode #(.DATA_W(DATA_W)) u_dec (.code(in_data), .law(law), .lin(conv_d));
      assign pass_d = OUT_W'(in_data);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= conv_en ? conv_d : pass_d;
      end
   end
endmodule

// File: rtl/pcm_compander.sv
module pcm_compander #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              law_sel,
   input  logic              inline_en,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_word_i,
   output logic              tx_valid_o,
   output logic [7:0]        tx_code_o,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_code_i,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_word_o,
   input  logic              svc_req_i,
   input  logic              svc_op_i,
   input  logic [DATA_W-1:0] svc_data_i,
   output logic              svc_valid_o,
   output logic [DATA_W-1:0] svc_data_o
);
   import cmp_pkg::*;

   if (DATA_W < 14 || DATA_W > 32) begin : g_bad_width
      $error("pcm_compander: DATA_W must lie in 14..32");
   end

   law_e law;
   assign law = law_e'(law_sel);

   cmp_stage #(.DATA_W(DATA_W), .TO_CODE(1'b1)) u_tx (
      .clk(clk), .rst_n(rst_n), .law(law), .conv_en(inline_en),
      .in_valid(tx_valid_i), .in_data(tx_word_i),
      .out_valid(tx_valid_o), .out_data(tx_code_o));

   cmp_stage #(.DATA_W(DATA_W), .TO_CODE(1'b0)) u_rx (
      .clk(clk), .rst_n(rst_n), .law(law), .conv_en(inline_en),
      .in_valid(rx_valid_i), .in_data(rx_code_i),
      .out_valid(rx_valid_o), .out_data(rx_word_o));

   // service port: private converters, never shared with the inline lanes
   logic [7:0]        svc_code;
   logic [DATA_W-1:0] svc_lin;

   cmp_encode #(.DATA_W(DATA_W)) u_svc_enc (.lin(svc_data_i), .law(law), .code(svc_code));
   cmp_decode #(.DATA_W(DATA_W)) u_svc_dec (.code(svc_data_i[7:0]), .law(law), .lin(svc_lin));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         svc_valid_o <= 1'b0;
         svc_data_o  <= '0;
      end else begin
         svc_valid_o <= svc_req_i;
         if (svc_req_i) svc_data_o <= svc_op_i ? svc_lin : DATA_W'(svc_code);
      end
   end
endmodule

// File: rtl/pcm_compander_chk.sv
module pcm_compander_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              law_sel,
   input logic              inline_en,
   input logic              tx_valid_i,
   input logic [DATA_W-1:0] tx_word_i,
   input logic              tx_valid_o,
   input logic [7:0]        tx_code_o,
   input logic              rx_valid_i,
   input logic [7:0]        rx_code_i,
   input logic              rx_valid_o,
   input logic [DATA_W-1:0] rx_word_o,
   input logic              svc_req_i,
   input logic              svc_op_i,
   input logic [DATA_W-1:0] svc_data_i,
   input logic              svc_valid_o,
   input logic [DATA_W-1:0] svc_data_o
);
   // R7
   tx_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_i |=> tx_valid_o);
   // R7
   rx_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_i |=> rx_valid_o);
   // R11
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid_i |=> (!tx_valid_o && $stable(tx_code_o)));
   // R11
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid_i |=> (!rx_valid_o && $stable(rx_word_o)));
   // R8
   tx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && !inline_en) |=> tx_code_o == $past(tx_word_i[7:0]));
   // R8
   rx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && !inline_en) |=> rx_word_o == DATA_W'($past(rx_code_i)));
   // R6
   a_clip_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && inline_en && !law_sel && $signed(tx_word_i) > 4095) |=> tx_code_o == 8'hAA);
   // R6
   mu_clip_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && inline_en && law_sel && $signed(tx_word_i) < -8192) |=> tx_code_o == 8'h00);
   // R9
   svc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req_i |=> svc_valid_o);
   // R9
   svc_code_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req_i && !svc_op_i) |=> svc_data_o[DATA_W-1:8] == '0);
endmodule

bind pcm_compander pcm_compander_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pcm_compander_tb.sv
module pcm_compander_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N_CYC      = 4000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        law_sel, inline_en;
   logic        tx_valid_i, rx_valid_i, svc_req_i, svc_op_i;
   logic [15:0] tx_word_i, svc_data_i;
   logic [7:0]  rx_code_i;
   logic        tx_valid_o, rx_valid_o, svc_valid_o;
   logic [7:0]  tx_code_o;
   logic [15:0] rx_word_o, svc_data_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_compander #(.DATA_W(16)) u_dut (.*);

   // ---------------- behavioural reference ----------------
   function automatic int ref_a_enc(int x);
      int sg, m, seg, thr, man;
      if (x > 4095) x = 4095;
      if (x < -4096) x = -4096;
      if (x >= 0) begin sg = 128; m = x; end else begin sg = 0; m = -x - 1; end
      seg = 0; thr = 32;
      while (seg < 7 && m >= thr) begin seg++; thr = thr * 2; end
      man = (seg == 0) ? m / 2 : (m >> seg) % 16;
      return (sg + seg * 16 + man) ^ 'h55;
   endfunction

   function automatic int ref_mu_enc(int x);
      int sg, m, seg, thr, man;
      if (x > 8191) x = 8191;
      if (x < -8192) x = -8192;
      if (x < 0) begin sg = 128; m = -x; end else begin sg = 0; m = x; end
      m = m + 33;
      if (m > 8191) m = 8191;
      seg = 0; thr = 64;
      while (seg < 7 && m >= thr) begin seg++; thr = thr * 2; end
      man = (m >> (seg + 1)) % 16;
      return 255 - (sg + seg * 16 + man);
   endfunction

   function automatic int ref_a_dec(int c);
      int t, seg, man, mag;
      t = c ^ 'h55; seg = (t / 16) % 8; man = t % 16;
      mag = (seg == 0) ? 2 * man + 1 : (2 * man + 33) * (1 << (seg - 1));
      return ((t >= 128) ? mag : -mag) & 'hFFFF;
   endfunction

   function automatic int ref_mu_dec(int c);
      int t, seg, man, mag;
      t = 255 - c; seg = (t / 16) % 8; man = t % 16;
      mag = (2 * man + 33) * (1 << seg) - 33;
      return ((t >= 128) ? -mag : mag) & 'hFFFF;
   endfunction

   function automatic int enc(bit mu, int x);
      return mu ? ref_mu_enc(x) : ref_a_enc(x);
   endfunction

   function automatic int dec(bit mu, int c);
      return mu ? ref_mu_dec(c) : ref_a_dec(c);
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   int edge_vals[16] = '{0, -1, 1, 31, 32, 4095, 4096, -4096, -4097,
                         8158, 8159, 8191, 8192, -8192, 32767, -32768};

   function automatic int pick_word();
      int r;
      r = int'($urandom_range(9));
      if (r < 3)      return edge_vals[$urandom_range(15)];
      else if (r < 5) return int'($urandom_range(65535)) - 32768;
      else            return int'($urandom_range(18000)) - 9000;
   endfunction

   // expectations for the next falling edge
   int    e_txv, e_txc, e_rxv, e_rxw, e_sv, e_sd;
   string t_tx, t_rx, t_sv;

   initial begin
      rst_n = 0; law_sel = 0; inline_en = 0;
      tx_valid_i = 0; rx_valid_i = 0; svc_req_i = 0; svc_op_i = 0;
      tx_word_i = '0; svc_data_i = '0; rx_code_i = '0;
      e_txv = 0; e_txc = 0; e_rxv = 0; e_rxw = 0; e_sv = 0; e_sd = 0;
      t_tx = "R1"; t_rx = "R1"; t_sv = "R1";
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "tx_valid_o", int'(tx_valid_o), 0);
      check("R1", "tx_code_o", int'(tx_code_o), 0);
      check("R1", "rx_valid_o", int'(rx_valid_o), 0);
      check("R1", "rx_word_o", int'(rx_word_o), 0);
      check("R1", "svc_valid_o", int'(svc_valid_o), 0);
      check("R1", "svc_data_o", int'(svc_data_o), 0);
      rst_n = 1;

      for (int cyc = 0; cyc < N_CYC; cyc++) begin
         int  xw, xs, cc;
         bit  mu, all_on;
         @(negedge clk);
         check("R7", "tx_valid_o", int'(tx_valid_o), e_txv);
         check(t_tx, "tx_code_o", int'(tx_code_o), e_txc);
         check("R7", "rx_valid_o", int'(rx_valid_o), e_rxv);
         check(t_rx, "rx_word_o", int'(rx_word_o), e_rxw);
         check("R9", "svc_valid_o", int'(svc_valid_o), e_sv);
         check(t_sv, "svc_data_o", int'(svc_data_o), e_sd);

         // new stimulus; first block walks every code on both laws
         mu         = (cyc < 512) ? cyc[8] : bit'($urandom_range(1));
         law_sel    = mu;
         inline_en  = (cyc < 512) ? 1'b1 : ((cyc % 7) != 3);
         tx_valid_i = (cyc < 512) ? 1'b1 : ($urandom_range(3) != 0);
         rx_valid_i = (cyc < 512) ? 1'b1 : ($urandom_range(3) != 0);
         svc_req_i  = ($urandom_range(3) != 0);
         svc_op_i   = bit'($urandom_range(1));
         xw = pick_word();
         tx_word_i = 16'(xw);
         cc = (cyc < 512) ? (cyc % 256) : int'($urandom_range(255));
         rx_code_i = 8'(cc);
         if (svc_op_i) svc_data_i = {8'($urandom_range(255)), 8'($urandom_range(255))};
         else          svc_data_i = 16'(pick_word());
         xs = int'($signed(svc_data_i));
         all_on = tx_valid_i && rx_valid_i && svc_req_i && inline_en;

         e_txv = int'(tx_valid_i);
         if (tx_valid_i) begin
            if (!inline_en) begin e_txc = xw & 'hFF; t_tx = "R8"; end
            else begin
               e_txc = enc(mu, xw);
               if ((!mu && (xw > 4095 || xw < -4096)) || (mu && (xw > 8191 || xw < -8192)))
                  t_tx = "R6";
               else t_tx = mu ? "R3" : "R2";
            end
         end else t_tx = "R11";

         e_rxv = int'(rx_valid_i);
         if (rx_valid_i) begin
            if (!inline_en) begin e_rxw = cc; t_rx = "R8"; end
            else begin e_rxw = dec(mu, cc); t_rx = mu ? "R5" : "R4"; end
         end else t_rx = "R11";

         e_sv = int'(svc_req_i);
         if (svc_req_i) begin
            e_sd = svc_op_i ? dec(mu, int'(svc_data_i[7:0])) : enc(mu, xs);
            t_sv = all_on ? "R10" : "R9";
         end else t_sv = "R11";
      end
      @(negedge clk);
      check(t_tx, "tx_code_o", int'(tx_code_o), e_txc);
      check(t_rx, "rx_word_o", int'(rx_word_o), e_rxw);
      check(t_sv, "svc_data_o", int'(svc_data_o), e_sd);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule